// File: doc/BRIEF.md
# Serial Boot PROM Word Reader

This block fetches a run of 16-bit words from a nonvolatile boot memory while the chip starts up. The memory is not wired to a parallel bus. For each word the block sends the word address out one bit at a time, and board-level logic turns that stream back into a parallel address. The board logic then returns the 16-bit word serially, and the block assembles it. The serial clock is the core clock divided by a ratio that is captured when a read job starts.

A job is started by pulsing `start` while the block is idle. The pulse carries a 22-bit start word address, a word count and a divide ratio. The block reads that many consecutive words. It hands each word to a consumer over a valid/ready pair and does not fetch the next word until the current one has been taken. When the last word has been accepted, the block pulses `done` and returns to idle.

Top module: `sprom_boot_reader`

## Requirements
- R1: After a synchronous reset the block is idle: `busy`, `done`, `rd_valid`, `prom_sclk`, `prom_sao` and `prom_latch` are all low.
- R2: The divide ratio is sampled with an accepted start. Values below 2 are raised to 2 and values above 16 are lowered to 16. Each serial bit period lasts exactly that many core cycles. `prom_sclk` is low for the first floor(ratio/2) cycles of a period and high for the rest.
- R3: `start` is acted on only while idle. A start pulse during a job changes neither the job's addresses nor its word count.
- R4: The first serial period begins in the cycle after start is accepted. In the first 22 periods of each word, `prom_sao` carries the word address, most significant bit first, one bit per period.
- R5: `prom_latch` is high for exactly the one serial period that follows the last address bit, and `prom_sao` is low during that period.
- R6: Two idle serial periods, with the clock running, follow the latch period. Then come 16 data periods. `prom_sdi` is sampled in the last core cycle of each data period, and the first bit sampled is the most significant bit of the word.
- R7: `rd_valid` rises in the cycle after the last data bit is sampled. `rd_data` and `rd_valid` stay unchanged until a cycle with `rd_ready` high, and valid drops after that cycle.
- R8: Each later word in a job uses the previous address plus one, modulo 2^22. Its first address period begins in the cycle after the previous word was accepted.
- R9: `done` is high for one cycle, in the cycle after the final word is accepted, and `busy` is low in that same cycle.
- R10: An accepted start with a word count of zero pulses `done` in the next cycle. It generates no serial activity and no words.
- R11: `prom_sclk`, `prom_sao` and `prom_latch` stay low whenever no serial period is in progress, that is while idle or while a word waits for the consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (accepted only when idle) |
| start_addr | input | ADDR_W (22) | First word address of the job |
| word_count | input | CNT_W (16) | Number of words to read |
| div_ratio | input | DIV_W (5) | Core cycles per serial bit, clamped to 2..16 |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at the end of a job |
| prom_sclk | output | 1 | Serial clock to the board conversion logic |
| prom_sao | output | 1 | Serial address bit |
| prom_latch | output | 1 | Address capture strobe |
| prom_sdi | input | 1 | Serial data bit from the board logic |
| rd_data | output | DATA_W (16) | Assembled word |
| rd_valid | output | 1 | rd_data holds an untaken word |
| rd_ready | input | 1 | Consumer takes the word |

## Verification
The embedded assertions check, on every cycle, the properties that hold locally. The serial pins stay quiet whenever the block is not shifting. A waiting word stays stable until it is taken. The latch strobe only ever follows a fully shifted address. The captured ratio is frozen for the whole job and lies inside 2..16. Only the bench's scenarios can show the properties that need a sequence of cycles: the exact period length and duty split for even, odd and clamped ratios, the bit order of address and data, address wrap across the top of the space, the ignored mid-job start and the zero-count job. The bench shows these by comparing every pin against its cycle model.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_LATCH = 3'd2,
    PH_WAIT  = 3'd3,
    PH_DATA  = 3'd4,
    PH_HOLD  = 3'd5
  } phase_t;
endpackage

// File: rtl/sprom_clkdiv.sv
module sprom_clkdiv #(
  parameter int DIV_W   = 5,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] ratio_in,
  input  logic             run,
  output logic             tick,
  output logic             sclk
);
  localparam logic [DIV_W-1:0] RMIN = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] RMAX = DIV_W'(DIV_MAX);

  logic [DIV_W-1:0] ratio_q, div_cnt, clamped;
  logic [DIV_W:0]   cnt_plus;
  logic             sclk_q;

  always_comb begin
    if (ratio_in < RMIN)      clamped = RMIN;
    else if (ratio_in > RMAX) clamped = RMAX;
    else                      clamped = ratio_in;
  end

  assign tick     = run && (div_cnt == ratio_q - DIV_W'(1));
  assign cnt_plus = {1'b0, div_cnt} + (DIV_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= RMIN;
    end else if (load) begin
      ratio_q <= clamped;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_cnt <= '0;
      sclk_q  <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      sclk_q  <= 1'b0;
    end else begin
      div_cnt <= cnt_plus[DIV_W-1:0];
      sclk_q  <= cnt_plus >= {2'b00, ratio_q[DIV_W-1:1]};
    end
  end

  assign sclk = sclk_q;

  a_r2_ratio_frozen: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> $stable(ratio_q));
  a_r2_ratio_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (ratio_q >= RMIN && ratio_q <= RMAX));
  a_r2_low_first: assert property (@(posedge clk) disable iff (rst)
    (run && div_cnt == '0) |-> !sclk_q);
endmodule

// File: rtl/sprom_outreg.sv
module sprom_outreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              ready,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              taken
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      data_q  <= din;
      valid_q <= 1'b1;
    end else if (valid_q && ready) begin
      valid_q <= 1'b0;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign taken = valid_q && ready;

  a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/sprom_seq.sv
module sprom_seq
  import sprom_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int DATA_W       = 16,
  parameter int CNT_W        = 16,
  parameter int WAIT_PERIODS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              tick,
  input  logic              sdi,
  input  logic              taken,
  output phase_t            phase,
  output logic              accept,
  output logic              sao,
  output logic              latch,
  output logic              load_word,
  output logic [DATA_W-1:0] word,
  output logic              done
);
  localparam int MAXAD = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int MAXB  = (MAXAD > WAIT_PERIODS) ? MAXAD : WAIT_PERIODS;
  localparam int BIT_W = $clog2(MAXB + 1);

  phase_t            phase_q;
  logic [BIT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] addr_sr, cur_addr, next_addr;
  logic [DATA_W-1:0] data_sr;
  logic [CNT_W-1:0]  left;
  logic              latch_q, done_q;

  assign accept    = (phase_q == PH_IDLE) && start;
  assign next_addr = cur_addr + ADDR_W'(1);
  assign word      = {data_sr[DATA_W-2:0], sdi};
  assign load_word = (phase_q == PH_DATA) && tick && (bit_cnt == BIT_W'(DATA_W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      bit_cnt  <= '0;
      addr_sr  <= '0;
      cur_addr <= '0;
      data_sr  <= '0;
      left     <= '0;
      latch_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start) begin
          if (word_count == '0) begin
            done_q <= 1'b1;
          end else begin
            phase_q  <= PH_ADDR;
            addr_sr  <= start_addr;
            cur_addr <= start_addr;
            left     <= word_count;
            bit_cnt  <= '0;
          end
        end
        PH_ADDR: if (tick) begin
          addr_sr <= addr_sr << 1;
          if (bit_cnt == BIT_W'(ADDR_W-1)) begin
            phase_q <= PH_LATCH;
            bit_cnt <= '0;
            latch_q <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + BIT_W'(1);
          end
        end
        PH_LATCH: if (tick) begin
          latch_q <= 1'b0;
          phase_q <= PH_WAIT;
        end
        PH_WAIT: if (tick) begin
          if (bit_cnt == BIT_W'(WAIT_PERIODS-1)) begin
            phase_q <= PH_DATA;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + BIT_W'(1);
          end
        end
        PH_DATA: if (tick) begin
          data_sr <= word;
          if (bit_cnt == BIT_W'(DATA_W-1)) begin
            phase_q <= PH_HOLD;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + BIT_W'(1);
          end
        end
        PH_HOLD: if (taken) begin
          if (left == CNT_W'(1)) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            left     <= left - CNT_W'(1);
            cur_addr <= next_addr;
            addr_sr  <= next_addr;
            phase_q  <= PH_ADDR;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase = phase_q;
  assign sao   = addr_sr[ADDR_W-1];
  assign latch = latch_q;
  assign done  = done_q;

  a_r5_latch_follows_addr: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_q) |-> ($past(phase_q) == PH_ADDR));
  a_r5_addr_drained: assert property (@(posedge clk) disable iff (rst)
    latch_q |-> (addr_sr == '0));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (phase_q == PH_IDLE));
endmodule

// File: rtl/sprom_boot_reader.sv
module sprom_boot_reader
  import sprom_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int DATA_W       = 16,
  parameter int CNT_W        = 16,
  parameter int DIV_W        = 5,
  parameter int DIV_MIN      = 2,
  parameter int DIV_MAX      = 16,
  parameter int WAIT_PERIODS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic [DIV_W-1:0]  div_ratio,
  output logic              busy,
  output logic              done,
  output logic              prom_sclk,
  output logic              prom_sao,
  output logic              prom_latch,
  input  logic              prom_sdi,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready
);
  phase_t            phase;
  logic              accept, tick, run, load_word, taken;
  logic [DATA_W-1:0] word;

  assign run  = (phase == PH_ADDR) || (phase == PH_LATCH) ||
                (phase == PH_WAIT) || (phase == PH_DATA);
  assign busy = (phase != PH_IDLE);

  sprom_clkdiv #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_div (
    .clk(clk), .rst(rst), .load(accept), .ratio_in(div_ratio),
    .run(run), .tick(tick), .sclk(prom_sclk)
  );

  sprom_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
              .WAIT_PERIODS(WAIT_PERIODS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .word_count(word_count), .tick(tick), .sdi(prom_sdi), .taken(taken),
    .phase(phase), .accept(accept), .sao(prom_sao), .latch(prom_latch),
    .load_word(load_word), .word(word), .done(done)
  );

  sprom_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .load(load_word), .din(word), .ready(rd_ready),
    .data(rd_data), .valid(rd_valid), .taken(taken)
  );

  a_r11_pins_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy || rd_valid) |-> (!prom_sclk && !prom_sao && !prom_latch));
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/tb_sprom_boot_reader.sv
module tb_sprom_boot_reader;
  localparam int NPER = 22 + 1 + 2 + 16;

  logic        clk = 1'b0, rst = 1'b1;
  logic        start = 1'b0, prom_sdi = 1'b0, rd_ready = 1'b1;
  logic [21:0] start_addr = '0;
  logic [15:0] word_count = '0;
  logic [4:0]  div_ratio = 5'd2;
  logic        busy, done, prom_sclk, prom_sao, prom_latch, rd_valid;
  logic [15:0] rd_data;

  int checks = 0, fails = 0, cyc = 0;
  int words_seen = 0, busy_seen = 0, stall = 0;

  sprom_boot_reader dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .word_count(word_count), .div_ratio(div_ratio), .busy(busy), .done(done),
    .prom_sclk(prom_sclk), .prom_sao(prom_sao), .prom_latch(prom_latch),
    .prom_sdi(prom_sdi), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [21:0] a);
    return a[15:0] ^ {a[21:16], 10'h000} ^ 16'h5A3C;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // cycle model of the expected pin behaviour
  int m_act = 0, m_per = 0, m_div = 0, m_n = 2, m_left = 0, m_widx = 0;
  logic [21:0] m_addr = '0;
  logic m_done = 1'b0;

  always @(posedge clk) begin
    m_done = 1'b0;
    if (rst) m_act = 0;
    else begin
      case (m_act)
        0: if (start) begin
          m_n = (div_ratio < 2) ? 2 : (div_ratio > 16) ? 16 : int'(div_ratio);
          if (word_count == 0) m_done = 1'b1;
          else begin
            m_act = 1; m_per = 0; m_div = 0; m_widx = 0;
            m_addr = start_addr; m_left = int'(word_count);
          end
        end
        1: if (m_div == m_n - 1) begin
          m_div = 0;
          if (m_per == NPER - 1) m_act = 2; else m_per++;
        end else m_div++;
        default: if (rd_ready) begin
          if (m_left == 1) begin m_act = 0; m_done = 1'b1; end
          else begin
            m_left--; m_addr = m_addr + 22'd1; m_widx++;
            m_act = 1; m_per = 0; m_div = 0;
          end
        end
      endcase
    end
  end

  // board conversion logic model
  int b_r = 0;
  logic b_prev = 1'b0;
  logic [21:0] b_addr = '0;

  always @(negedge clk) begin
    cyc++;
    rd_ready = (stall != 0) ? (cyc % 4 == 3) : 1'b1;
    if (!rst) begin
      chk((m_act == 1) ? "R2" : "R11", "sclk", int'(prom_sclk),
          int'(m_act == 1 && m_div >= m_n / 2));
      chk((m_widx > 0) ? "R8" : "R4", "sao", int'(prom_sao),
          int'(m_act == 1 && m_per < 22 && m_addr[21 - (m_per < 22 ? m_per : 0)]));
      chk("R5", "latch", int'(prom_latch), int'(m_act == 1 && m_per == 22));
      chk("R9", "busy", int'(busy), int'(m_act != 0));
      chk("R9", "done", int'(done), int'(m_done));
      chk("R7", "valid", int'(rd_valid), int'(m_act == 2));
      if (rd_valid && m_act == 2) chk("R6", "rd_data", int'(rd_data), int'(mem_word(m_addr)));
      if (busy) busy_seen++;
      if (rd_valid && rd_ready) words_seen++;
    end
    if (!busy || rd_valid) b_r = 0;
    else if (prom_sclk && !b_prev) begin
      if (b_r < 22) b_addr = {b_addr[20:0], prom_sao};
      else if (b_r >= 25) begin
        logic [15:0] w;
        w = mem_word(b_addr);
        prom_sdi = w[15 - (b_r - 25)];
      end
      b_r++;
    end
    b_prev = prom_sclk;
  end

  task automatic run_job(input logic [21:0] a, input int cnt, input logic [4:0] r,
                         input int stl, input int inject);
    int k;
    @(negedge clk);
    stall = stl; start_addr = a; word_count = 16'(cnt); div_ratio = r; start = 1'b1;
    words_seen = 0; busy_seen = 0;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done) begin
      @(negedge clk);
      k++;
      if (inject != 0 && k == 300) begin
        start = 1'b1; start_addr = 22'h155555; word_count = 16'd9; div_ratio = 5'd2;
      end
      if (inject != 0 && k == 301) start = 1'b0;
    end
    chk("R3", "words delivered", words_seen, cnt);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    chk("R1", "sclk|sao|latch|done", int'(prom_sclk | prom_sao | prom_latch | done), 0);
    run_job(22'h000010, 3, 5'd2, 0, 0);   // R2 fastest ratio, R8 increments
    run_job(22'h3FFFFE, 3, 5'd31, 1, 1);  // R2 clamp high, R8 wrap, R3 ignored start, R7 stalls
    run_job(22'h0ABCDE, 1, 5'd0, 1, 0);   // R2 clamp low
    run_job(22'h000123, 2, 5'd3, 0, 0);   // R2 odd ratio
    run_job(22'h000777, 0, 5'd5, 0, 0);   // R10 zero count
    chk("R10", "busy cycles", busy_seen, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule